// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a 32-bit down-counting watchdog. Software arms it once, picks one of sixteen timeout ranges, and then has to keep restarting it by writing a fixed key value to a restart register. If the count reaches zero before a restart arrives, the watchdog responds in one of two ways. In the direct mode it fires a system reset pulse at once. In the two-stage mode the first expiry only raises an interrupt. If that interrupt is still pending when the next expiry arrives, the reset pulse fires.

The reset pulse has a programmable width. Registers are reached through a simple valid/write/address/data port. Reads are combinational from the address, and the live count can be read at any time. Once the enable bit has been set, only the block's own reset can clear it.

Top module: `wdog_two_stage`

## Requirements
- R1: The 32-bit count decrements by one each cycle while enabled, holds 0 while disabled, and can be read at any time at address 5 (COUNT).
- R2: With range index n, the preset is 2^(BASE_EXP+n)-1. The count reloads the preset on enable, on every timeout and on every valid restart. A timeout is a cycle in which the enabled count equals 0, so the timeout period is 2^(BASE_EXP+n) cycles.
- R3: In mode 0 (CTRL bit1 = 0), a timeout starts the reset pulse on the next cycle, and the interrupt is not touched.
- R4: In mode 1 (CTRL bit1 = 1), a timeout with no pending interrupt sets the interrupt on the next cycle without a reset. The pending flag reads as bit0 of address 4 (ISTAT).
- R5: In mode 1, a timeout while the interrupt is pending starts the reset pulse. Writing 1 to bit0 of ISTAT clears the pending flag. A clear written in the same cycle as the timeout still lets the reset fire, and it leaves the flag cleared.
- R6: A pulse-width field f (address 2, bits[2:0]) keeps sys_rst_o high for exactly 2^(f+1) cycles (2 to 256). A timeout during an active pulse restarts the pulse at full width.
- R7: A restart happens only when the 32-bit value 0x00000076 is written to address 3 (KICK) while the block is enabled. Any other value has no effect. A restart in the same cycle as a zero count takes priority, so no timeout occurs in that cycle.
- R8: CTRL (address 0) bit0 is the enable and can only be set. Writing 0 to it does not disable the watchdog. CTRL reads back as {mode, enable} in bits[1:0].
- R9: RANGE (address 1, bits[3:0]) holds the range index. A new index takes effect at the next reload.
- R10: In reset, all state is 0, both outputs are low, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Pending first-stage interrupt |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The hardest case to reach is a restart or an interrupt clear landing in exactly the cycle in which the count sits at zero. A clear there must not prevent the second-stage reset, and a restart there must prevent the timeout. The bench keeps its own cycle-accurate expectation of the count, which tells it which cycle holds the zero. Directed passes drive the clear and the key write into that cycle. Random phases with short ranges (4 to 32 cycle periods) and frequent kicks, clears, wrong keys and width changes hit the same collisions, and they also hit pulses retriggered by a timeout.

// File: rtl/wdog_pkg.sv
// Shared address decode for the two-stage watchdog.
// Assumes a 3-bit register address space; unused addresses read zero.
package wdog_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_RANGE = 3'd1,
        A_PULSE = 3'd2,
        A_KICK  = 3'd3,
        A_ISTAT = 3'd4,
        A_COUNT = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/wdog_regs.sv
// Register file of the watchdog: sticky enable, mode, range and pulse width.
// Decodes the one-cycle restart, start and interrupt-clear strobes.
// Assumes one access per cycle; a read has no side effect.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int RANGE_W = 4,
    parameter int PW_W    = 3,
    parameter logic [DATA_W-1:0] KEY = 32'h0000_0076
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic               en_o,
    output logic               mode_o,
    output logic [RANGE_W-1:0] range_o,
    output logic [PW_W-1:0]    pw_o,
    output logic               start_o,
    output logic               kick_o,
    output logic               clr_o
);
    logic wr;
    logic hit_ctrl;
    logic hit_range;
    logic hit_pulse;

    // Decode write strobes for each register.
    always_comb begin
        wr        = bus_valid && bus_write;
        hit_ctrl  = wr && (bus_addr == A_CTRL);
        hit_range = wr && (bus_addr == A_RANGE);
        hit_pulse = wr && (bus_addr == A_PULSE);
        start_o   = hit_ctrl && bus_wdata[0] && !en_o;
        kick_o    = wr && (bus_addr == A_KICK) && (bus_wdata == KEY) && en_o;
        clr_o     = wr && (bus_addr == A_ISTAT) && bus_wdata[0];
    end

    // Hold configuration; enable can only be set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o    <= 1'b0;
            mode_o  <= 1'b0;
            range_o <= '0;
            pw_o    <= '0;
        end else begin
            if (hit_ctrl) begin
                en_o   <= en_o | bus_wdata[0];
                mode_o <= bus_wdata[1];
            end
            if (hit_range) range_o <= bus_wdata[RANGE_W-1:0];
            if (hit_pulse) pw_o    <= bus_wdata[PW_W-1:0];
        end
    end

    assert_enable_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |=> en_o);
endmodule

// File: rtl/wdog_counter.sv
// Down counter of the watchdog. Loads the preset for the selected range on
// start, restart and timeout, and flags a timeout when the enabled count is 0.
// Assumes BASE_EXP + 2^RANGE_W - 1 < CNT_W so every preset fits.
module wdog_counter #(
    parameter int CNT_W    = 32,
    parameter int RANGE_W  = 4,
    parameter int BASE_EXP = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               start_i,
    input  logic               kick_i,
    input  logic [RANGE_W-1:0] range_i,
    output logic [CNT_W-1:0]   count_o,
    output logic               timeout_o
);
    logic [CNT_W-1:0] preset;

    // Preset for range n is 2^(BASE_EXP+n) - 1.
    function automatic logic [CNT_W-1:0] preset_of(input logic [RANGE_W-1:0] n);
        logic [63:0] full;
        full = (64'd1 << (BASE_EXP + int'(n))) - 64'd1;
        return full[CNT_W-1:0];
    endfunction

    // Timeout when the count is zero, unless a restart arrives in that cycle.
    always_comb begin
        preset    = preset_of(range_i);
        timeout_o = en_i && (count_o == '0) && !kick_i;
    end

    // Reload or count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (start_i || kick_i || timeout_o) begin
            count_o <= preset;
        end else if (en_i) begin
            count_o <= count_o - 1'b1;
        end
    end

    assert_idle_count_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (count_o == '0));

    assert_kick_blocks_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> (count_o != '0));
endmodule

// File: rtl/wdog_resp.sv
// Response stage: turns timeouts into an interrupt or a reset pulse,
// depending on the mode, and times the reset pulse width.
// Assumes timeout_i is a single-cycle strobe.
module wdog_resp #(
    parameter int PW_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            timeout_i,
    input  logic            mode_i,
    input  logic [PW_W-1:0] pw_i,
    input  logic            clr_i,
    output logic            irq_o,
    output logic            sys_rst_o
);
    localparam int PCNT_W = (1 << PW_W) + 1;

    logic              rst_trig;
    logic              irq_set;
    logic [PCNT_W-1:0] width;
    logic [PCNT_W-1:0] pulse_q;

    // Decide between the first stage and the reset stage.
    always_comb begin
        rst_trig  = timeout_i && (!mode_i || irq_o);
        irq_set   = timeout_i && mode_i && !irq_o;
        width     = {{(PCNT_W-1){1'b0}}, 1'b1} << (int'(pw_i) + 1);
        sys_rst_o = (pulse_q != '0);
    end

    // Pending interrupt: a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_o <= 1'b0;
        else if (irq_set) irq_o <= 1'b1;
        else if (clr_i)   irq_o <= 1'b0;
    end

    // Reset pulse counter, restarted by every reset trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)                pulse_q <= '0;
        else if (rst_trig)         pulse_q <= width;
        else if (pulse_q != '0)    pulse_q <= pulse_q - 1'b1;
    end

    assert_stage2_needs_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sys_rst_o) && $past(mode_i)) |-> $past(irq_o));

    assert_irq_only_in_mode1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(mode_i));
endmodule

// File: rtl/wdog_two_stage.sv
// Top of the two-stage watchdog: register file, down counter and response
// stage, plus the combinational read mux. Assumes DATA_W >= CNT_W.
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int DATA_W   = 32,
    parameter int RANGE_W  = 4,
    parameter int PW_W     = 3,
    parameter int BASE_EXP = 16,
    parameter logic [DATA_W-1:0] KEY = 32'h0000_0076
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_o
);
    logic               en;
    logic               mode;
    logic [RANGE_W-1:0] range_sel;
    logic [PW_W-1:0]    pw_sel;
    logic               start;
    logic               kick;
    logic               clr;
    logic [CNT_W-1:0]   count;
    logic               timeout;

    wdog_regs #(
        .DATA_W(DATA_W), .RANGE_W(RANGE_W), .PW_W(PW_W), .KEY(KEY)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .en_o(en), .mode_o(mode), .range_o(range_sel), .pw_o(pw_sel),
        .start_o(start), .kick_o(kick), .clr_o(clr)
    );

    wdog_counter #(
        .CNT_W(CNT_W), .RANGE_W(RANGE_W), .BASE_EXP(BASE_EXP)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .en_i(en), .start_i(start), .kick_i(kick), .range_i(range_sel),
        .count_o(count), .timeout_o(timeout)
    );

    wdog_resp #(
        .PW_W(PW_W)
    ) u_resp (
        .clk(clk), .rst_n(rst_n),
        .timeout_i(timeout), .mode_i(mode), .pw_i(pw_sel), .clr_i(clr),
        .irq_o(irq_o), .sys_rst_o(sys_rst_o)
    );

    // Read mux selected by the address alone.
    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = DATA_W'({mode, en});
            A_RANGE: bus_rdata = DATA_W'(range_sel);
            A_PULSE: bus_rdata = DATA_W'(pw_sel);
            A_ISTAT: bus_rdata = DATA_W'(irq_o);
            A_COUNT: bus_rdata = DATA_W'(count);
            default: bus_rdata = '0;
        endcase
    end

    assert_rst_follows_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> $past(en && (count == '0)));

    assert_irq_follows_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(en && (count == '0)));
endmodule

// File: tb/wdog_two_stage_tb_top.sv
module wdog_two_stage_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BEXP       = 2;
    localparam logic [31:0] GOOD_KEY = 32'h76;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        sys_rst_o;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_two_stage #(.BASE_EXP(BEXP)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .sys_rst_o(sys_rst_o)
    );

    // Expected state, derived from the requirements.
    logic        m_en, m_mode, m_irq;
    logic [3:0]  m_range;
    logic [2:0]  m_pw;
    logic [31:0] m_cnt;
    int          m_pulse;

    function automatic logic [31:0] exp_preset(input logic [3:0] n);
        return (32'd1 << (BEXP + int'(n))) - 32'd1;
    endfunction

    function automatic logic [31:0] exp_rdata(input logic [2:0] a);
        case (a)
            3'd0: return {30'd0, m_mode, m_en};
            3'd1: return {28'd0, m_range};
            3'd2: return {29'd0, m_pw};
            3'd4: return {31'd0, m_irq};
            3'd5: return m_cnt;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R8";
            3'd1: return "R9";
            3'd2: return "R6";
            3'd4: return "R5";
            3'd5: return "R1 R2 R7";
            default: return "R10";
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic wr, kick, start, clr, to, trig, setirq;
        if (!rst_n) begin
            m_en = 0; m_mode = 0; m_irq = 0; m_range = 0; m_pw = 0;
            m_cnt = 0; m_pulse = 0;
        end else begin
            wr     = bus_valid && bus_write;
            kick   = wr && bus_addr == 3'd3 && bus_wdata == GOOD_KEY && m_en;
            start  = wr && bus_addr == 3'd0 && bus_wdata[0] && !m_en;
            clr    = wr && bus_addr == 3'd4 && bus_wdata[0];
            to     = m_en && m_cnt == 0 && !kick;
            trig   = to && (!m_mode || m_irq);
            setirq = to && m_mode && !m_irq;
            if (start || kick || to) m_cnt = exp_preset(m_range);
            else if (m_en)           m_cnt = m_cnt - 1;
            if (trig)              m_pulse = 1 << (int'(m_pw) + 1);
            else if (m_pulse > 0)  m_pulse = m_pulse - 1;
            if (setirq)    m_irq = 1;
            else if (clr)  m_irq = 0;
            if (wr && bus_addr == 3'd0) begin
                m_en = m_en | bus_wdata[0];
                m_mode = bus_wdata[1];
            end
            if (wr && bus_addr == 3'd1) m_range = bus_wdata[3:0];
            if (wr && bus_addr == 3'd2) m_pw = bus_wdata[2:0];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Wait for the falling edge and compare all outputs with the model.
    task automatic cycle();
        @(negedge clk);
        if (rst_n) begin
            chk("R4 R5 irq", {31'd0, irq_o}, {31'd0, m_irq});
            chk("R3 R6 sys_rst", {31'd0, sys_rst_o}, {31'd0, (m_pulse != 0)});
            chk(rd_tag(bus_addr), bus_rdata, exp_rdata(bus_addr));
        end
    endtask

    task automatic drive(input logic v, input logic w, input logic [2:0] a, input logic [31:0] d);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle();
        drive(1'b1, 1'b0, 3'd5, 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        idle();
        repeat (2) @(negedge clk);
        chk("R10 irq", {31'd0, irq_o}, 32'd0);
        chk("R10 sys_rst", {31'd0, sys_rst_o}, 32'd0);
        chk("R10 count", bus_rdata, 32'd0);
        rst_n = 1;
    endtask

    task automatic config_wd(input logic mode, input logic [3:0] rng, input logic [2:0] pw);
        cycle(); drive(1, 1, 3'd1, {28'd0, rng});
        cycle(); drive(1, 1, 3'd2, {29'd0, pw});
        cycle(); drive(1, 1, 3'd0, {30'd0, mode, 1'b1});
        cycle(); idle();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        int run;
        bit seen, done;
        void'($urandom(32'd20240611));

        // R10 reset state, then R8 enable cannot be cleared.
        do_reset();
        config_wd(1'b0, 4'd3, 3'd0);
        cycle(); drive(1, 1, 3'd0, 32'd0);
        cycle(); drive(1, 0, 3'd0, 32'd0);
        cycle();
        chk("R8 enable sticky", bus_rdata & 32'd1, 32'd1);
        idle();

        // R6 pulse width 256 on a long period, mode 0 (R3).
        do_reset();
        config_wd(1'b0, 4'd8, 3'd7);
        run = 0; seen = 0; done = 0;
        for (int i = 0; i < 3000 && !done; i++) begin
            cycle();
            if (sys_rst_o) begin seen = 1; run++; end
            else if (seen) done = 1;
        end
        chk("R6 pulse width 256", run, 32'd256);
        chk("R3 pulse seen", {31'd0, seen}, 32'd1);

        // R7 restart in the cycle the count is zero wins over timeout.
        do_reset();
        config_wd(1'b0, 4'd1, 3'd0);
        done = 0;
        for (int i = 0; i < 200 && !done; i++) begin
            cycle();
            if (m_en && m_cnt == 0 && m_pulse == 0) begin
                drive(1, 1, 3'd3, GOOD_KEY);
                cycle(); idle();
                chk("R7 kick at zero blocks reset", {31'd0, sys_rst_o}, 32'd0);
                done = 1;
            end
        end
        chk("R7 zero-cycle kick reached", {31'd0, done}, 32'd1);

        // R5 clear in the same cycle as the second timeout: reset still fires.
        do_reset();
        config_wd(1'b1, 4'd0, 3'd1);
        done = 0;
        for (int i = 0; i < 200 && !done; i++) begin
            cycle();
            if (m_irq && m_cnt == 0) begin
                drive(1, 1, 3'd4, 32'd1);
                cycle(); idle();
                chk("R5 reset despite late clear", {31'd0, sys_rst_o}, 32'd1);
                chk("R5 late clear drops irq", {31'd0, irq_o}, 32'd0);
                done = 1;
            end
        end
        chk("R5 aligned clear reached", {31'd0, done}, 32'd1);

        // R4 and R5: an early clear avoids the reset and re-arms the interrupt.
        do_reset();
        config_wd(1'b1, 4'd2, 3'd0);
        for (int i = 0; i < 40; i++) begin
            cycle();
            if (irq_o) drive(1, 1, 3'd4, 32'd1); else idle();
        end
        chk("R5 early clears keep reset low", {31'd0, sys_rst_o}, 32'd0);

        // Random phases: mode 0, mode 1, mixed, restart-heavy.
        for (int ph = 0; ph < 4; ph++) begin
            do_reset();
            config_wd(ph == 1 || ph == 3, 4'($urandom % 3), 3'($urandom % 3));
            for (int i = 0; i < 6000; i++) begin
                int r;
                logic [31:0] d;
                logic md;
                cycle();
                r = $urandom % 100;
                md = (ph == 0) ? 1'b0 : (ph == 1 || ph == 3) ? 1'b1 : 1'($urandom);
                if (r < 3)        drive(1, 1, 3'd0, {$urandom, md, 1'($urandom)} );
                else if (r < 6)   drive(1, 1, 3'd1, 32'($urandom % 4));
                else if (r < 8)   drive(1, 1, 3'd2, 32'($urandom % 4));
                else if (r < ((ph == 3) ? 40 : 18)) drive(1, 1, 3'd3, GOOD_KEY);
                else if (r < 50) begin
                    d = $urandom;
                    if (d == GOOD_KEY) d = d ^ 32'h100;
                    drive(1, 1, 3'd3, d);
                end else if (r < 58) drive(1, 1, 3'd4, 32'($urandom % 2));
                else              drive(1'($urandom), 1'b0, 3'($urandom % 8), $urandom);
            end
        end

        cycle();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule